// File: doc/BRIEF.md
# Reset Filter and Boot Configuration Sequencer

This block brings a small 16-bit microcontroller core out of power-on or pin reset. It takes the active-low reset pin through a two-flop synchronizer and accepts a reset only after the pin has stayed low for a minimum number of state times. One state time is two oscillator periods. Shorter glitches are ignored. While reset is accepted the core is held. The block also generates the clock-output pin, a free-running divide-by-two of the oscillator.

When the synchronized pin goes high, the clock-output divider is forced to a known phase and a fixed boot sequence of ten state times begins. In the first state time it raises a strobe that clears the processor status word. In two later state times it reads one byte each from the configuration addresses 16'h2018 and 16'h201A over a plain read port and stores them in two configuration registers. In the last state time it presents the start vector 16'h2080 with a program-counter load strobe, and then releases the core. A new low on the pin during the sequence aborts it at once. A separate asynchronous power-on input puts every register into its defined initial state.

Top module: `rst_boot_seq`

## Requirements
- R1: From run, a reset is accepted (in_reset rises) only after the synchronized pin has been low for at least 16 state times (32 oscillator cycles). A low pulse of 28 oscillator cycles or fewer leaves core_run at 1 and changes nothing.
- R2: clkout toggles on every oscillator cycle outside the resynchronizing edge, which gives half the oscillator frequency at 50% duty.
- R3: The edge that leaves the held state forces clkout to 0. State times of the boot sequence start on that edge: clkout is 0 in the first cycle of each state time and 1 in the second.
- R4: From the first cycle with in_reset at 0, exactly 20 oscillator cycles (10 state times) pass with in_reset and core_run both 0. core_run is 1 in cycle 20.
- R5: psw_clr is 1 during boot state time 0 (boot cycles 0 and 1) only.
- R6: mem_rd is 1 only in boot state time 2, with mem_addr 16'h2018, and in boot state time 4, with mem_addr 16'h201A. mem_rdata is sampled on the last cycle of each of these state times into cfg0 and cfg1 respectively. mem_addr is 0 when mem_rd is 0.
- R7: pc_load is 1 during boot state time 9 only, with pc_value 16'h2080. core_run follows on the next cycle.
- R8: A synchronized low during the boot sequence returns the block to the held state on the third clock edge after the pin falls. A configuration byte captured earlier in that boot keeps its new value, and one not yet read keeps its old value.
- R9: With por_n low, in_reset is 1, core_run, psw_clr, mem_rd and pc_load are 0, and cfg0 and cfg1 are 8'h00. Outside the boot sequence cfg0 and cfg1 never change, whatever mem_rdata does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| mem_rdata | input | 8 | Read data for the current mem_addr |
| mem_rd | output | 1 | Configuration byte read request |
| mem_addr | output | 16 | Configuration byte address |
| cfg0 | output | 8 | Configuration register loaded from 16'h2018 |
| cfg1 | output | 8 | Configuration register loaded from 16'h201A |
| psw_clr | output | 1 | Strobe clearing the processor status word |
| pc_load | output | 1 | Program-counter load strobe |
| pc_value | output | 16 | Start vector, 16'h2080 |
| in_reset | output | 1 | Core held in reset |
| core_run | output | 1 | Boot finished, core executing |
| clkout | output | 1 | Clock output, oscillator divided by two |

## Verification
A wrong step count or a wrong divider phase appears at the ports within the boot it corrupts. The strobes, the read addresses or clkout land in the wrong boot cycle, or core_run arrives before or after cycle 20. A low-time counter that fails to clear or saturate shows as a short pulse that stops the core, or a long one that does not, within a few tens of cycles. A capture or abort fault leaves cfg0 or cfg1 different from the byte the memory model offered once core_run rises.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   typedef enum logic [1:0] {
      ST_HELD = 2'd0,
      ST_BOOT = 2'd1,
      ST_RUN  = 2'd2
   } boot_state_t;
endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d_async,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rbs_clkdiv.sv
module rbs_clkdiv (
   input  logic clk,
   input  logic por_n,
   input  logic resync,
   output logic phase
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      phase <= 1'b0;
      else if (resync) phase <= 1'b0;
      else             phase <= ~phase;
   end
endmodule

// File: rtl/rbs_low_filter.sv
module rbs_low_filter #(
   parameter int LOW_MIN = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_hi,
   input  logic st_end,
   output logic reset_seen
);
   localparam int CNT_W = $clog2(LOW_MIN + 1);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LOW_MIN);

   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                         low_cnt <= CNT_SAT;
      else if (pin_hi)                    low_cnt <= '0;
      else if (st_end && low_cnt != CNT_SAT) low_cnt <= low_cnt + 1'b1;
   end

   assign reset_seen = (low_cnt == CNT_SAT);
endmodule

// File: rtl/rbs_boot_fsm.sv
module rbs_boot_fsm
   import rbs_pkg::*;
#(
   parameter int            ADDR_W    = 16,
   parameter int            DATA_W    = 8,
   parameter int            BOOT_LEN  = 10,
   parameter int            CFG0_STEP = 2,
   parameter int            CFG1_STEP = 4,
   parameter logic [15:0]   CFG0_ADDR = 16'h2018,
   parameter logic [15:0]   CFG1_ADDR = 16'h201A,
   parameter logic [7:0]    CFG_INIT  = 8'h00
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pin_hi,
   input  logic              reset_seen,
   input  logic              st_end,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              resync,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] cfg0,
   output logic [DATA_W-1:0] cfg1,
   output logic              psw_clr,
   output logic              pc_load,
   output logic              in_reset,
   output logic              core_run
);
   localparam int STEP_W = $clog2(BOOT_LEN);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(BOOT_LEN - 1);
   localparam logic [STEP_W-1:0] STEP_C0   = STEP_W'(CFG0_STEP);
   localparam logic [STEP_W-1:0] STEP_C1   = STEP_W'(CFG1_STEP);

   boot_state_t       state;
   logic [STEP_W-1:0] step;
   logic              in_boot;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state <= ST_HELD;
         step  <= '0;
         cfg0  <= DATA_W'(CFG_INIT);
         cfg1  <= DATA_W'(CFG_INIT);
      end else begin
         case (state)
            ST_HELD: begin
               if (pin_hi) begin
                  state <= ST_BOOT;
                  step  <= '0;
               end
            end
            ST_BOOT: begin
               if (!pin_hi) begin
                  state <= ST_HELD;
               end else if (st_end) begin
                  if (step == STEP_C0) cfg0 <= mem_rdata;
                  if (step == STEP_C1) cfg1 <= mem_rdata;
                  if (step == STEP_LAST) state <= ST_RUN;
                  else                   step  <= step + 1'b1;
               end
            end
            ST_RUN: begin
               if (reset_seen) state <= ST_HELD;
            end
            default: state <= ST_HELD;
         endcase
      end
   end

   always_comb begin
      in_boot  = (state == ST_BOOT);
      in_reset = (state == ST_HELD);
      core_run = (state == ST_RUN);
      resync   = in_reset && pin_hi;
      psw_clr  = in_boot && (step == '0);
      pc_load  = in_boot && (step == STEP_LAST);
      mem_rd   = in_boot && ((step == STEP_C0) || (step == STEP_C1));
      mem_addr = '0;
      if (mem_rd) mem_addr = (step == STEP_C1) ? ADDR_W'(CFG1_ADDR) : ADDR_W'(CFG0_ADDR);
   end
endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq #(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          LOW_MIN     = 16,
   parameter int          BOOT_LEN    = 10,
   parameter int          CFG0_STEP   = 2,
   parameter int          CFG1_STEP   = 4,
   parameter logic [15:0] CFG0_ADDR   = 16'h2018,
   parameter logic [15:0] CFG1_ADDR   = 16'h201A,
   parameter logic [15:0] START_VEC   = 16'h2080,
   parameter logic [7:0]  CFG_INIT    = 8'h00
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] cfg0,
   output logic [DATA_W-1:0] cfg1,
   output logic              psw_clr,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_value,
   output logic              in_reset,
   output logic              core_run,
   output logic              clkout
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rst_boot_seq: SYNC_STAGES must be at least 2");
      end
      if (LOW_MIN < 2) begin : g_bad_low
         $error("rst_boot_seq: LOW_MIN must be at least 2");
      end
      if (BOOT_LEN < 3) begin : g_bad_len
         $error("rst_boot_seq: BOOT_LEN must be at least 3");
      end
      if (!(CFG0_STEP > 0 && CFG0_STEP < CFG1_STEP && CFG1_STEP < BOOT_LEN - 1)) begin : g_bad_step
         $error("rst_boot_seq: read steps must lie strictly inside the sequence, in order");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("rst_boot_seq: ADDR_W must hold the fixed addresses");
      end
   endgenerate

   logic pin_hi;
   logic phase;
   logic reset_seen;
   logic resync;

   rbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .por_n   (por_n),
      .d_async (rst_pin_n),
      .q       (pin_hi)
   );

   rbs_clkdiv u_div (
      .clk    (clk),
      .por_n  (por_n),
      .resync (resync),
      .phase  (phase)
   );

   rbs_low_filter #(.LOW_MIN(LOW_MIN)) u_filt (
      .clk        (clk),
      .por_n      (por_n),
      .pin_hi     (pin_hi),
      .st_end     (phase),
      .reset_seen (reset_seen)
   );

   rbs_boot_fsm #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BOOT_LEN  (BOOT_LEN),
      .CFG0_STEP (CFG0_STEP),
      .CFG1_STEP (CFG1_STEP),
      .CFG0_ADDR (CFG0_ADDR),
      .CFG1_ADDR (CFG1_ADDR),
      .CFG_INIT  (CFG_INIT)
   ) u_fsm (
      .clk        (clk),
      .por_n      (por_n),
      .pin_hi     (pin_hi),
      .reset_seen (reset_seen),
      .st_end     (phase),
      .mem_rdata  (mem_rdata),
      .resync     (resync),
      .mem_rd     (mem_rd),
      .mem_addr   (mem_addr),
      .cfg0       (cfg0),
      .cfg1       (cfg1),
      .psw_clr    (psw_clr),
      .pc_load    (pc_load),
      .in_reset   (in_reset),
      .core_run   (core_run)
   );

   assign clkout   = phase;
   assign pc_value = ADDR_W'(START_VEC);
endmodule

// File: rtl/rst_boot_seq_chk.sv
module rst_boot_seq_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int LOW_MIN  = 16,
   parameter int BOOT_LEN = 10
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_pin_n,
   input logic              mem_rd,
   input logic [DATA_W-1:0] cfg0,
   input logic [DATA_W-1:0] cfg1,
   input logic              psw_clr,
   input logic              pc_load,
   input logic              in_reset,
   input logic              core_run,
   input logic              clkout
);
   localparam int BC_W = $clog2(2 * BOOT_LEN + 2) + 1;
   localparam int LC_W = $clog2(2 * LOW_MIN + 2) + 1;
   localparam logic [LC_W-1:0] LC_MAX = LC_W'(2 * LOW_MIN);

   logic [BC_W-1:0] boot_cyc;
   logic [LC_W-1:0] pin_low_cyc;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         boot_cyc <= '0;
      else if (in_reset)  boot_cyc <= '0;
      else if (!core_run) boot_cyc <= boot_cyc + 1'b1;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                    pin_low_cyc <= '0;
      else if (rst_pin_n)            pin_low_cyc <= '0;
      else if (pin_low_cyc != LC_MAX) pin_low_cyc <= pin_low_cyc + 1'b1;
   end

   // R1
   p_low_time_r1: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(in_reset) && $past(core_run)) |-> (pin_low_cyc >= LC_W'(2 * LOW_MIN - 1)));

   // R2
   p_clk_toggle_r2: assert property (@(posedge clk) disable iff (!por_n)
      (core_run && $past(core_run)) |-> (clkout != $past(clkout)));

   // R3
   p_resync_r3: assert property (@(posedge clk) disable iff (!por_n)
      $fell(in_reset) |-> !clkout);

   // R4
   p_boot_len_r4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_run) |-> (boot_cyc == BC_W'(2 * BOOT_LEN)));

   // R5
   p_psw_first_r5: assert property (@(posedge clk) disable iff (!por_n)
      $fell(in_reset) |-> psw_clr);

   // R6
   p_rd_in_boot_r6: assert property (@(posedge clk) disable iff (!por_n)
      mem_rd |-> (!in_reset && !core_run));

   // R7
   p_pc_before_run_r7: assert property (@(posedge clk) disable iff (!por_n)
      $rose(core_run) |-> $past(pc_load));

   // R9
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      ((in_reset || core_run) && $past(in_reset || core_run)) |-> ($stable(cfg0) && $stable(cfg1)));

   // R5 and R7 never overlap
   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({psw_clr, pc_load, mem_rd}));
endmodule

bind rst_boot_seq rst_boot_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LOW_MIN  (LOW_MIN),
   .BOOT_LEN (BOOT_LEN)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_pin_n (rst_pin_n),
   .mem_rd    (mem_rd),
   .cfg0      (cfg0),
   .cfg1      (cfg1),
   .psw_clr   (psw_clr),
   .pc_load   (pc_load),
   .in_reset  (in_reset),
   .core_run  (core_run),
   .clkout    (clkout)
);

// File: tb/rst_boot_seq_tb_top.sv
`timescale 1ns/1ps
module rst_boot_seq_tb_top;
   logic        clk = 1'b0;
   logic        por_n;
   logic        rst_pin_n;
   logic [7:0]  mem_rdata;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  cfg0, cfg1;
   logic        psw_clr, pc_load, in_reset, core_run, clkout;
   logic [15:0] pc_value;

   logic [7:0]  m0, m1;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   rst_boot_seq dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .rst_pin_n (rst_pin_n),
      .mem_rdata (mem_rdata),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .cfg0      (cfg0),
      .cfg1      (cfg1),
      .psw_clr   (psw_clr),
      .pc_load   (pc_load),
      .pc_value  (pc_value),
      .in_reset  (in_reset),
      .core_run  (core_run),
      .clkout    (clkout)
   );

   // memory model: offers the current contents at the two configuration addresses
   always_comb begin
      if (mem_addr == 16'h2018)      mem_rdata = m0;
      else if (mem_addr == 16'h201A) mem_rdata = m1;
      else                           mem_rdata = 8'hEE;
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // expected port vector {clkout, psw_clr, mem_rd, mem_addr, pc_load, in_reset, core_run} for boot cycle k
   function automatic logic [21:0] exp_boot(input int k);
      int st = k / 2;
      logic [15:0] a = (st == 2) ? 16'h2018 : (st == 4) ? 16'h201A : 16'h0000;
      return {(k % 2) == 1, st == 0, (st == 2) || (st == 4), a, st == 9, 1'b0, 1'b0};
   endfunction

   task automatic check_boot(input string tag);
      int waited = 0;
      @(negedge clk);
      while (in_reset && waited < 12) begin
         @(negedge clk);
         waited++;
      end
      chk(!in_reset, {tag, " R3 boot start after release"}, 32'(in_reset), 0);
      for (int k = 0; k < 20; k++) begin
         logic [21:0] act = {clkout, psw_clr, mem_rd, mem_addr, pc_load, in_reset, core_run};
         chk(act == exp_boot(k), $sformatf("%s R3 R4 R5 R6 R7 boot cycle %0d", tag, k), 32'(act), 32'(exp_boot(k)));
         if (pc_load) chk(pc_value == 16'h2080, {tag, " R7 start vector"}, 32'(pc_value), 32'h2080);
         @(negedge clk);
      end
      chk(core_run && !in_reset, {tag, " R4 core runs after 10 state times"}, 32'(core_run), 1);
      chk({cfg0, cfg1} == {m0, m1}, {tag, " R6 configuration bytes"}, 32'({cfg0, cfg1}), 32'({m0, m1}));
   endtask

   // low pulse on the pin while running; short pulses must be ignored (R1)
   task automatic short_pulse(input int len, input string tag);
      logic [15:0] cfg_before = {cfg0, cfg1};
      bit stayed = 1'b1;
      rst_pin_n = 1'b0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (!core_run) stayed = 1'b0;
      end
      rst_pin_n = 1'b1;
      m0 = 8'($urandom); m1 = 8'($urandom);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!core_run) stayed = 1'b0;
      end
      chk(stayed, $sformatf("%s R1 short low of %0d cycles ignored", tag, len), 32'(stayed), 1);
      chk({cfg0, cfg1} == cfg_before, {tag, " R9 cfg unchanged in run"}, 32'({cfg0, cfg1}), 32'(cfg_before));
   endtask

   task automatic long_pulse(input int len, input string tag);
      logic [15:0] cfg_before = {cfg0, cfg1};
      rst_pin_n = 1'b0;
      repeat (len) @(negedge clk);
      chk(in_reset && !core_run, $sformatf("%s R1 low of %0d cycles accepted", tag, len), 32'(in_reset), 1);
      m0 = 8'($urandom); m1 = 8'($urandom);
      @(negedge clk);
      chk({cfg0, cfg1} == cfg_before, {tag, " R9 cfg unchanged while held"}, 32'({cfg0, cfg1}), 32'(cfg_before));
      rst_pin_n = 1'b1;
      check_boot(tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_0421));
      por_n = 1'b0;
      rst_pin_n = 1'b0;
      m0 = 8'hA5; m1 = 8'h3C;
      repeat (3) @(negedge clk);
      chk(in_reset && !core_run && !psw_clr && !mem_rd && !pc_load, "R9 reset state strobes",
          32'({in_reset, core_run, psw_clr, mem_rd, pc_load}), 32'h10);
      chk({cfg0, cfg1} == 16'h0000, "R9 reset state cfg", 32'({cfg0, cfg1}), 0);
      por_n = 1'b1;
      repeat (40) @(negedge clk);
      chk(in_reset, "R1 held while pin low after power-on", 32'(in_reset), 1);
      rst_pin_n = 1'b1;
      check_boot("first boot");

      // clock output keeps toggling in run (R2)
      begin
         logic prev = clkout;
         bit good = 1'b1;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (clkout == prev) good = 1'b0;
            prev = clkout;
         end
         chk(good, "R2 clkout toggles every cycle", 32'(good), 1);
      end

      short_pulse(28, "directed");
      short_pulse(2, "directed");
      long_pulse(36, "directed");

      // abort in the middle of boot after the first byte is captured (R8)
      begin
         logic [7:0] old1;
         rst_pin_n = 1'b0;
         repeat (40) @(negedge clk);
         old1 = cfg1;
         m0 = 8'h5A; m1 = old1 ^ 8'hFF;
         rst_pin_n = 1'b1;
         while (!mem_rd) @(negedge clk);
         @(negedge clk);
         rst_pin_n = 1'b0;
         repeat (2) @(negedge clk);
         chk(!in_reset, "R8 not yet aborted two edges after fall", 32'(in_reset), 0);
         @(negedge clk);
         chk(in_reset && !core_run, "R8 abort on third edge", 32'(in_reset), 1);
         chk(cfg0 == 8'h5A, "R8 earlier byte kept", 32'(cfg0), 32'h5A);
         chk(cfg1 == old1, "R8 later byte not written", 32'(cfg1), 32'(old1));
         repeat (40) @(negedge clk);
         m0 = 8'($urandom); m1 = 8'($urandom);
         rst_pin_n = 1'b1;
         check_boot("after abort");
      end

      for (int it = 0; it < 30; it++) begin
         int len;
         if ($urandom_range(1, 0) == 1) begin
            len = $urandom_range(60, 36);
            long_pulse(len, "random");
         end else begin
            len = $urandom_range(28, 1);
            short_pulse(len, "random");
         end
         repeat ($urandom_range(10, 3)) @(negedge clk);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule